// File: doc/BRIEF.md
# Fractional multiply-subtract unit

The unit multiplies two signed fixed-point fractions and subtracts the scaled product from an accumulator. The result is either 32 bits wide, taken from the low accumulator word, or 64 bits wide, taken from the high and low words together. Each multiplicand is used as a full word or as one of its halfwords. An optional one-bit fractional shift doubles the product so that the binary point lines up. The result either wraps or saturates, and four status flags report what happened: overflow, sticky overflow, advanced overflow and sticky advanced overflow.

All arithmetic is combinational. A strobe registers the result and the flags on the next rising clock edge, and nothing else changes them. The sticky flags accumulate across operations and are cleared only by an explicit clear input.

Top module: `fmsub_unit`

## Requirements
- R1: `mode_i` selects the operands. Code 0 uses both multiplicands as full words. Code 1 replaces B with its sign-extended bits [15:0]. Code 2 replaces B with its sign-extended bits [31:16]. Code 3 applies the bits [15:0] selection to both A and B. Code 4 applies the bits [31:16] selection to both. Codes 5 to 7 behave as code 0.
- R2: The single-product word result (codes 0 to 2, `wide_i`=0) works as follows. The signed product is shifted right arithmetically by 32−n in code 0 and by 16−n in codes 1 and 2. One is added when any discarded bit was nonzero. The sum is subtracted from the sign-extended `acc_lo_i`. The low 32 bits go to `res_lo_o`, and `res_hi_o` is 0 in every word-result mode.
- R3: In word results, V is set when the exact difference lies outside [−2^31, 2^31−1]. In doubleword results, V is set when the exact difference lies outside [−2^63, 2^63−1].
- R4: In the non-saturating single-product modes, V is inverted from the R3 value when n=1 and both selected operands equal 0x80000000.
- R5: In the halfword-pair modes (codes 3 and 4), the 32-bit product is doubled when n=1. A doubled value of 0x80000000 is replaced by 0x7FFFFFFF. In word results the value is sign-extended and subtracted from `acc_lo_i`.
- R6: In the halfword-pair modes with `wide_i`=1, the corrected product is sign-extended to 64 bits, shifted left by 16, and subtracted from {`acc_hi_i`,`acc_lo_i`}.
- R7: In the single-product modes with `wide_i`=1, the full product is doubled when n=1 and then subtracted from the 64-bit accumulator. The result wraps to 64 bits.
- R8: With `sat_i`=1, an out-of-range difference is clamped to the largest or smallest value of the result width, according to its sign. V then reports the R3 overflow without the R4 inversion.
- R9: AV is bit 31 XOR bit 30 of the result in word modes, and bit 63 XOR bit 62 in doubleword modes.
- R10: SV becomes SV OR V on each strobed operation, and SAV becomes SAV OR AV. `flag_clr_i` zeroes both. When a clear and a strobe arrive in the same cycle, the new V and AV are still merged in.
- R11: Reset zeroes the result and all flags. Without `valid_i`, the result, V and AV hold their values, and SV and SAV hold unless `flag_clr_i` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| mode_i | input | 3 | Operand selection code (R1) |
| wide_i | input | 1 | 1: 64-bit accumulator and result |
| frac_sh_i | input | 1 | Fractional shift n |
| sat_i | input | 1 | Saturate instead of wrap |
| flag_clr_i | input | 1 | Clear the sticky flags |
| acc_lo_i | input | 32 | Accumulator low word |
| acc_hi_i | input | 32 | Accumulator high word |
| mul_a_i | input | 32 | Multiplicand A |
| mul_b_i | input | 32 | Multiplicand B |
| res_lo_o | output | 32 | Result low word |
| res_hi_o | output | 32 | Result high word (0 for word results) |
| v_o | output | 1 | Overflow |
| sv_o | output | 1 | Sticky overflow |
| av_o | output | 1 | Advanced overflow |
| sav_o | output | 1 | Sticky advanced overflow |

## Verification
The hardest cases to reach are the ones where the arithmetic sits exactly on a boundary. One is the minimum-times-minimum product, which flips V in the wrapping modes but not in the saturating ones. Another is the halfword product that doubles to exactly 0x80000000. A third is a product whose discarded fraction is only a single low bit. The sweep covers them all by crossing a small set of operand words with every mode, shift, width and saturate setting, and against several accumulators. The operand words are 0x80000000, 0x80008000, 1, all-ones and maximum-positive. The accumulators sit at the range limits, so that each boundary value is combined with both overflow directions.

// File: rtl/fmsub_pkg.sv
package fmsub_pkg;
  typedef enum logic [2:0] {
    MD_FULL = 3'd0,
    MD_B_LO = 3'd1,
    MD_B_HI = 3'd2,
    MD_P_LO = 3'd3,
    MD_P_HI = 3'd4
  } fmsub_mode_e;
endpackage

// File: rtl/fmsub_opsel.sv
module fmsub_opsel
  import fmsub_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]        a_i,
  input  logic [W-1:0]        b_i,
  input  logic [2:0]          mode_i,
  output logic signed [W-1:0] a_op_o,
  output logic signed [W-1:0] b_op_o,
  output logic                pair_o,
  output logic                full_o
);
  localparam int H = W / 2;

  logic signed [W-1:0] a_lo, a_hi, b_lo, b_hi;
  assign a_lo = {{H{a_i[H-1]}}, a_i[H-1:0]};
  assign a_hi = {{H{a_i[W-1]}}, a_i[W-1:H]};
  assign b_lo = {{H{b_i[H-1]}}, b_i[H-1:0]};
  assign b_hi = {{H{b_i[W-1]}}, b_i[W-1:H]};

  always_comb begin
    a_op_o = a_i;
    b_op_o = b_i;
    pair_o = 1'b0;
    full_o = 1'b0;
    case (fmsub_mode_e'(mode_i))
      MD_B_LO: b_op_o = b_lo;
      MD_B_HI: b_op_o = b_hi;
      MD_P_LO: begin a_op_o = a_lo; b_op_o = b_lo; pair_o = 1'b1; end
      MD_P_HI: begin a_op_o = a_hi; b_op_o = b_hi; pair_o = 1'b1; end
      default: full_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/fmsub_prod.sv
module fmsub_prod #(
  parameter int W = 32
) (
  input  logic signed [W-1:0]     a_op_i,
  input  logic signed [W-1:0]     b_op_i,
  input  logic                    pair_i,
  input  logic                    full_i,
  input  logic                    wide_i,
  input  logic                    n_i,
  output logic signed [2*W+3:0]   sub_o,
  output logic                    special_o
);
  localparam int H  = W / 2;
  localparam int PW = 2 * W;
  localparam int AW = 2 * W + 4;
  localparam int SW = $clog2(PW) + 1;
  localparam logic [W-1:0] MINW = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXW = {1'b0, {(W-1){1'b1}}};

  logic signed [PW-1:0] prod, shr, scaled;
  logic [PW-1:0]        rmask;
  logic [SW-1:0]        sh;
  logic                 rnd;
  logic signed [W-1:0]  pw, dbl;
  logic signed [AW-1:0] ext_dbl, ext_prod, ext_scaled;

  assign prod  = a_op_i * b_op_i;
  assign sh    = (full_i ? SW'(W) : SW'(H)) - SW'(n_i);
  assign rmask = ({{(PW-1){1'b0}}, 1'b1} << sh) - {{(PW-1){1'b0}}, 1'b1};
  assign rnd   = |(prod & rmask);
  assign shr   = prod >>> sh;
  assign scaled = shr + $signed({{(PW-1){1'b0}}, rnd});

  // halfword pair: doubling, with the min*min product pinned below +1.0
  assign pw = prod[W-1:0];
  always_comb begin
    dbl = n_i ? (pw <<< 1) : pw;
    if (n_i && dbl == MINW) dbl = MAXW;
  end

  assign ext_dbl    = dbl;
  assign ext_prod   = prod;
  assign ext_scaled = scaled;

  always_comb begin
    case ({wide_i, pair_i})
      2'b11:   sub_o = ext_dbl <<< H;
      2'b01:   sub_o = ext_dbl;
      2'b10:   sub_o = n_i ? (ext_prod <<< 1) : ext_prod;
      default: sub_o = ext_scaled;
    endcase
  end

  assign special_o = !pair_i && n_i && a_op_i == MINW && b_op_i == MINW;
endmodule

// File: rtl/fmsub_sat.sv
module fmsub_sat #(
  parameter int W = 32
) (
  input  logic [W-1:0]           acc_lo_i,
  input  logic [W-1:0]           acc_hi_i,
  input  logic signed [2*W+3:0]  sub_i,
  input  logic                   wide_i,
  input  logic                   sat_i,
  input  logic                   special_i,
  output logic [2*W-1:0]         res_o,
  output logic                   ovf_o,
  output logic                   v_o,
  output logic                   av_o
);
  localparam int AW = 2 * W + 4;
  localparam int DW = 2 * W;

  logic signed [AW-1:0] acc_x, diff;
  logic ovf_w, ovf_d, neg;

  always_comb begin
    if (wide_i) acc_x = $signed({acc_hi_i, acc_lo_i});
    else        acc_x = $signed(acc_lo_i);
  end

  assign diff  = acc_x - sub_i;
  assign ovf_w = !((&diff[AW-1:W-1]) || !(|diff[AW-1:W-1]));
  assign ovf_d = !((&diff[AW-1:DW-1]) || !(|diff[AW-1:DW-1]));
  assign ovf_o = wide_i ? ovf_d : ovf_w;
  assign neg   = diff[AW-1];

  always_comb begin
    if (sat_i && ovf_o) begin
      if (wide_i) res_o = neg ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
      else        res_o = {{W{1'b0}}, (neg ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}})};
    end else if (wide_i) begin
      res_o = diff[DW-1:0];
    end else begin
      res_o = {{W{1'b0}}, diff[W-1:0]};
    end
  end

  assign v_o  = ovf_o ^ (special_i && !sat_i);
  assign av_o = wide_i ? (res_o[DW-1] ^ res_o[DW-2]) : (res_o[W-1] ^ res_o[W-2]);
endmodule

// File: rtl/fmsub_unit.sv
module fmsub_unit #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [2:0]   mode_i,
  input  logic         wide_i,
  input  logic         frac_sh_i,
  input  logic         sat_i,
  input  logic         flag_clr_i,
  input  logic [W-1:0] acc_lo_i,
  input  logic [W-1:0] acc_hi_i,
  input  logic [W-1:0] mul_a_i,
  input  logic [W-1:0] mul_b_i,
  output logic [W-1:0] res_lo_o,
  output logic [W-1:0] res_hi_o,
  output logic         v_o,
  output logic         sv_o,
  output logic         av_o,
  output logic         sav_o
);
  localparam int AW = 2 * W + 4;

  logic signed [W-1:0]  a_op, b_op;
  logic                 pair, full, special, ovf, v_nxt, av_nxt;
  logic signed [AW-1:0] sub;
  logic [2*W-1:0]       res_nxt;

  fmsub_opsel #(.W(W)) u_opsel (
    .a_i(mul_a_i), .b_i(mul_b_i), .mode_i(mode_i),
    .a_op_o(a_op), .b_op_o(b_op), .pair_o(pair), .full_o(full)
  );

  fmsub_prod #(.W(W)) u_prod (
    .a_op_i(a_op), .b_op_i(b_op), .pair_i(pair), .full_i(full),
    .wide_i(wide_i), .n_i(frac_sh_i), .sub_o(sub), .special_o(special)
  );

  fmsub_sat #(.W(W)) u_sat (
    .acc_lo_i(acc_lo_i), .acc_hi_i(acc_hi_i), .sub_i(sub),
    .wide_i(wide_i), .sat_i(sat_i), .special_i(special),
    .res_o(res_nxt), .ovf_o(ovf), .v_o(v_nxt), .av_o(av_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_lo_o <= '0;
      res_hi_o <= '0;
      v_o      <= 1'b0;
      av_o     <= 1'b0;
      sv_o     <= 1'b0;
      sav_o    <= 1'b0;
    end else begin
      if (valid_i) begin
        res_lo_o <= res_nxt[W-1:0];
        res_hi_o <= res_nxt[2*W-1:W];
        v_o      <= v_nxt;
        av_o     <= av_nxt;
      end
      sv_o  <= (sv_o  && !flag_clr_i) || (valid_i && v_nxt);
      sav_o <= (sav_o && !flag_clr_i) || (valid_i && av_nxt);
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !flag_clr_i |=> $stable(res_lo_o) && $stable(res_hi_o) && $stable(v_o)
                               && $stable(av_o) && $stable(sv_o) && $stable(sav_o)); // R11
  AST_SV_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && v_nxt |=> sv_o && v_o); // R10
  AST_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i && !valid_i |=> !sv_o && !sav_o); // R10
  AST_SAT_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sat_i && ovf && !wide_i |=>
      (res_lo_o == {1'b0, {(W-1){1'b1}}} || res_lo_o == {1'b1, {(W-1){1'b0}}}) && v_o); // R8
  AST_WORD_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !wide_i |=> res_hi_o == '0); // R2
endmodule

// File: tb/sim_fmsub_unit.sv
module sim_fmsub_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, wide = 1'b0, nsh = 1'b0, sat = 1'b0, clr = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [31:0] acc_lo = '0, acc_hi = '0, ma = '0, mb = '0;
  logic [31:0] res_lo, res_hi;
  logic        v, sv, av, sav;

  int n_chk = 0, n_fail = 0;
  logic e_sv = 1'b0, e_sav = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmsub_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .mode_i(mode), .wide_i(wide),
    .frac_sh_i(nsh), .sat_i(sat), .flag_clr_i(clr), .acc_lo_i(acc_lo), .acc_hi_i(acc_hi),
    .mul_a_i(ma), .mul_b_i(mb), .res_lo_o(res_lo), .res_hi_o(res_hi),
    .v_o(v), .sv_o(sv), .av_o(av), .sav_o(sav)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic signed [127:0] sx16(input logic [15:0] x);
    return {{112{x[15]}}, x};
  endfunction
  function automatic logic signed [127:0] sx32(input logic [31:0] x);
    return {{96{x[31]}}, x};
  endfunction

  // arithmetic reference
  function automatic void model(input logic [31:0] a, b, lo, hi, input logic [2:0] md,
                                input logic w, n, s, output logic [63:0] res,
                                output logic ev, output logic eav);
    logic signed [127:0] ao, bo, p, q, acc, d, lim, two31;
    logic pr, ovf;
    int k;
    two31 = 128'sd1 <<< 31;
    pr = (md == 3'd3) || (md == 3'd4);
    ao = (md == 3'd3) ? sx16(a[15:0]) : (md == 3'd4) ? sx16(a[31:16]) : sx32(a);
    bo = (md == 3'd1 || md == 3'd3) ? sx16(b[15:0]) :
         (md == 3'd2 || md == 3'd4) ? sx16(b[31:16]) : sx32(b);
    p = ao * bo;
    if (pr) begin
      if (n) begin
        p = p * 2;
        if (p == two31) p = two31 - 1;
      end
      q = w ? p * 65536 : p;
    end else if (w) begin
      q = n ? p * 2 : p;
    end else begin
      k = ((md == 3'd1 || md == 3'd2) ? 16 : 32) - int'(n);
      q = p >>> k;
      if (p - (q <<< k) != 0) q = q + 1;
    end
    acc = w ? {{64{hi[31]}}, hi, lo} : sx32(lo);
    d = acc - q;
    lim = w ? (128'sd1 <<< 63) : two31;
    ovf = (d >= lim) || (d < -lim);
    if (s && ovf) d = (d < 0) ? -lim : lim - 1;
    res = w ? d[63:0] : {32'd0, d[31:0]};
    ev = ovf ^ (!s && !pr && n && ao == -two31 && bo == -two31);
    eav = w ? (res[63] ^ res[62]) : (res[31] ^ res[30]);
  endfunction

  function automatic logic [31:0] opv(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      5: return 32'h8000_8000;
      6: return 32'h7FFF_8001;
      default: return 32'h1234_5678;
    endcase
  endfunction

  function automatic logic [63:0] accv(input int i);
    case (i)
      0: return 64'h0;
      1: return 64'h7FFF_FFFF_7FFF_FFFF;
      2: return 64'h8000_0000_8000_0000;
      default: return 64'hFFFF_FFFF_0000_ABCD;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] eres;
    logic ev, eav;
    int cnt;
    string rtag, vtag;
    cnt = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset res", {res_hi, res_lo}, 64'h0);
    chk("R11 reset flags", {60'd0, v, sv, av, sav}, 64'h0);
    rst_n = 1'b1;
    for (int md = 0; md < 5; md++)
      for (int ia = 0; ia < 8; ia++)
        for (int ib = 0; ib < 8; ib++)
          for (int ic = 0; ic < 4; ic++)
            for (int cfg = 0; cfg < 8; cfg++) begin
              @(negedge clk);
              mode = 3'(md); ma = opv(ia); mb = opv(ib);
              {acc_hi, acc_lo} = accv(ic);
              wide = cfg[0]; nsh = cfg[1]; sat = cfg[2];
              valid = 1'b1;
              clr = (cnt % 7) == 3;
              model(ma, mb, acc_lo, acc_hi, mode, wide, nsh, sat, eres, ev, eav);
              e_sv  = (e_sv  && !clr) || ev;
              e_sav = (e_sav && !clr) || eav;
              @(negedge clk);
              valid = 1'b0; clr = 1'b0;
              if (sat) rtag = "R8 R1 sat result";
              else if (md >= 3) rtag = wide ? "R6 R1 pair dword" : "R5 R1 pair word";
              else rtag = wide ? "R7 R1 dword" : "R2 R1 word";
              vtag = (!sat && md == 0 && nsh && ma == 32'h8000_0000 && mb == 32'h8000_0000)
                     ? "R4 V inverted" : (sat ? "R8 V" : "R3 V");
              chk(rtag, {res_hi, res_lo}, eres);
              chk(vtag, {63'd0, v}, {63'd0, ev});
              chk("R9 AV", {63'd0, av}, {63'd0, eav});
              chk("R10 SV SAV", {62'd0, sv, sav}, {62'd0, e_sv, e_sav});
              // R11: idle cycle with changed inputs leaves outputs unchanged
              if ((cnt % 13) == 5) begin
                ma = ~ma; mb = mb ^ 32'h5A5A_0F0F; acc_lo = ~acc_lo; wide = ~wide;
                @(negedge clk);
                chk("R11 hold res", {res_hi, res_lo}, eres);
                chk("R11 hold flags", {60'd0, v, sv, av, sav}, {60'd0, ev, e_sv, eav, e_sav});
              end
              // R10: clear with no strobe zeroes sticky flags
              if ((cnt % 29) == 11) begin
                clr = 1'b1;
                @(negedge clk);
                clr = 1'b0;
                e_sv = 1'b0; e_sav = 1'b0;
                chk("R10 clear", {62'd0, sv, sav}, 64'h0);
              end
              cnt++;
            end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule